// File: doc/BRIEF.md
# SECDED Protected Word Memory

A synchronous memory of 512 words, 64 bits each. Every word is stored as a 72-bit codeword: the 64 data bits, seven Hamming check bits and one overall parity bit. Each read decodes the stored codeword. A single-bit error is corrected in the returned data. A double-bit error is reported but not corrected. A two-bit status goes out alongside the read data.

Correction changes only the returned value. The storage keeps the faulty bit. Every later read of that location reports and repairs the same error again, until the word is written anew. For fault injection, a write-side flip mask is XORed into the codeword before it is stored. A parameter adds one output register stage, which costs one cycle of read latency.

Top module: `secded_mem`

## Requirements
- R1: When `wr_en` is high at a rising edge, the word on `wr_data` is stored at `wr_addr` (512 locations). A later read of an uncorrupted location returns that word with status 00.
- R2: The stored codeword is 72 bits, numbered 0 to 71.
  - Bit 0 gives even parity over all 72 bits.
  - Bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits. Check bit 2^k is the even parity of the codeword positions 1..71 whose index has bit k set.
  - Data bit j sits at the j-th index in 1..71, in ascending order, that is not a power of two.
  - `wr_flip` is XORed bitwise into the codeword as it is written.
- R3: When exactly one of the 72 stored bits differs from its encoded value, the read returns the original data word with status 01.
- R4: When exactly two stored bits differ, the read returns status 10. The data is the raw stored data bits with no correction applied.
- R5: `rd_status` never takes the value 11.
- R6: Correction never repairs the storage. Repeated reads of a location holding a single-bit error keep returning status 01 and corrected data until that location is rewritten.
- R7: With `OUT_REG`=0, a read issued by `rd_en` at edge k is presented after edge k+1. With `OUT_REG`=1, it is presented after edge k+2, exactly one cycle later.
- R8: `rd_data` and `rd_status` change together, and only when a read result arrives. They hold their values otherwise.
- R9: A read and a write to the same address at the same edge return the contents from before the write.
- R10: After reset, `rd_data` is zero and `rd_status` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read pipeline |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_flip | input | 72 | Codeword bits to invert as the word is stored |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read address |
| rd_data | output | 64 | Read data, corrected where possible |
| rd_status | output | 2 | 00 clean, 01 single corrected, 10 double detected |

## Verification
The assertions check these rules on every cycle:
- the status is never 11;
- the outputs change only when a result is loaded;
- for every decoded read, a clean result re-encodes to exactly the stored codeword;
- a corrected result re-encodes to a codeword one bit away from the stored one;
- a double result lies at least two bits away.

The bench scenarios check the rest:
- the exact latency of each pipeline variant;
- read-first behaviour on address collisions;
- that the faulty bit stays in storage across repeated reads until a rewrite clears it;
- the uncorrected data returned for double errors.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CW_W   = DATA_W + HAM_W + 1;

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam logic [1:0] ST_CLEAN  = 2'b00;
    localparam logic [1:0] ST_FIXED  = 2'b01;
    localparam logic [1:0] ST_DOUBLE = 2'b10;

    function automatic bit is_pow2(int i);
        return (i & (i - 1)) == 0;
    endfunction

    // place data bits on the non power-of-two positions, ascending
    function automatic cw_t scatter(word_t d);
        cw_t c;
        int  j;
        c = '0;
        j = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                c[i] = d[j];
                j++;
            end
        end
        return c;
    endfunction

    function automatic word_t gather(cw_t c);
        word_t d;
        int    j;
        d = '0;
        j = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                d[j] = c[i];
                j++;
            end
        end
        return d;
    endfunction

    function automatic logic [HAM_W-1:0] syndrome(cw_t c);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int k = 0; k < HAM_W; k++) begin
            for (int i = 1; i < CW_W; i++) begin
                if (i[k]) s[k] = s[k] ^ c[i];
            end
        end
        return s;
    endfunction

    function automatic cw_t encode(word_t d);
        cw_t              c;
        logic [HAM_W-1:0] s;
        c = scatter(d);
        s = syndrome(c);
        for (int k = 0; k < HAM_W; k++) c[2**k] = s[k];
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  word_t data_i,
    input  cw_t   flip_i,
    output cw_t   cw_o
);
    assign cw_o = encode(data_i) ^ flip_i;
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  cw_t        cw_i,
    output word_t      data_o,
    output logic [1:0] st_o
);
    logic [HAM_W-1:0] syn;
    logic             par_odd;
    cw_t              fixed;

    always_comb begin
        syn     = syndrome(cw_i);
        par_odd = ^cw_i;
        fixed   = cw_i;
        data_o  = gather(cw_i);
        st_o    = ST_CLEAN;
        if (!par_odd) begin
            if (syn != '0) st_o = ST_DOUBLE;
        end else if (syn == '0) begin
            st_o = ST_FIXED;              // only the overall parity bit flipped
        end else if (int'(syn) < CW_W) begin
            fixed[syn] = ~cw_i[syn];
            data_o     = gather(fixed);
            st_o       = ST_FIXED;
        end else begin
            st_o = ST_DOUBLE;             // syndrome points outside the word
        end
    end
endmodule

// File: rtl/secded_array.sv
module secded_array
    import secded_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  cw_t               wr_cw_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output cw_t               rd_cw_o
);
    localparam int DEPTH = 1 << ADDR_W;

    cw_t mem_q [DEPTH];
    cw_t rd_cw_q;

    // the read samples the old word, so a same-address write is seen later
    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_addr_i] <= wr_cw_i;
        if (rd_en_i) rd_cw_q <= mem_q[rd_addr_i];
    end

    assign rd_cw_o = rd_cw_q;
endmodule

// File: rtl/secded_mem.sv
module secded_mem
    import secded_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int OUT_REG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW_W-1:0]   wr_flip,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_status
);
    typedef struct packed {
        logic       arr_vld;
        logic       dec_vld;
        word_t      dec_data;
        logic [1:0] dec_st;
    } pipe_t;

    cw_t        wr_cw;
    cw_t        arr_cw;
    word_t      fix_data;
    logic [1:0] fix_st;
    logic       out_load;
    pipe_t      p_d, p_q;

    secded_enc i_enc (
        .data_i (wr_data),
        .flip_i (wr_flip),
        .cw_o   (wr_cw)
    );

    secded_array #(.ADDR_W(ADDR_W)) i_array (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_cw_i   (wr_cw),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_cw_o   (arr_cw)
    );

    secded_dec i_dec (
        .cw_i   (arr_cw),
        .data_o (fix_data),
        .st_o   (fix_st)
    );

    always_comb begin
        p_d         = p_q;
        p_d.arr_vld = rd_en;
        p_d.dec_vld = p_q.arr_vld;
        if (p_q.arr_vld) begin
            p_d.dec_data = fix_data;
            p_d.dec_st   = fix_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    generate
        if (OUT_REG == 1) begin : g_oreg
            typedef struct packed {
                word_t      data;
                logic [1:0] st;
            } oreg_t;
            oreg_t o_d, o_q;

            always_comb begin
                o_d = o_q;
                if (p_q.dec_vld) begin
                    o_d.data = p_q.dec_data;
                    o_d.st   = p_q.dec_st;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) o_q <= '0;
                else        o_q <= o_d;
            end

            assign rd_data   = o_q.data;
            assign rd_status = o_q.st;
            assign out_load  = p_q.dec_vld;
        end else begin : g_noreg
            assign rd_data   = p_q.dec_data;
            assign rd_status = p_q.dec_st;
            assign out_load  = p_q.arr_vld;
        end
    endgenerate

    // R5
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status != 2'b11);

    // R8
    output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_load |=> ($stable(rd_data) && $stable(rd_status)));

    // R1
    clean_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.arr_vld && fix_st == ST_CLEAN) |-> (encode(fix_data) == arr_cw));

    // R3
    single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.arr_vld && fix_st == ST_FIXED) |-> ($countones(encode(fix_data) ^ arr_cw) == 1));

    // R4
    double_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.arr_vld && fix_st == ST_DOUBLE) |-> ($countones(encode(gather(arr_cw)) ^ arr_cw) >= 2));
endmodule

// File: tb/test_secded_mem.sv
module test_secded_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [71:0] wr_flip = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [63:0] q0_data, q1_data;
    logic [1:0]  q0_st, q1_st;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] mdl_data [512];
    logic [71:0] mdl_flip [512];
    logic [8:0]  used [512];
    int          n_used = 0;
    logic [63:0] prev1_data = '0;
    logic [1:0]  prev1_st = '0;

    always #4 clk = ~clk;

    secded_mem #(.ADDR_W(9), .OUT_REG(0)) i_secded_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_flip(wr_flip), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(q0_data), .rd_status(q0_st));

    secded_mem #(.ADDR_W(9), .OUT_REG(1)) i_secded_mem_oreg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_flip(wr_flip), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(q1_data), .rd_status(q1_st));

    // data bit j lives at the j-th non power-of-two index in 1..71 (R2)
    function automatic logic [63:0] flip_to_data(logic [71:0] m);
        logic [63:0] r;
        int n;
        r = '0;
        n = 0;
        for (int i = 1; i < 72; i++) begin
            if ((i & (i - 1)) != 0) begin
                r[n] = m[i];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_data(logic [63:0] d, logic [71:0] m);
        if ($countones(m) == 2) return d ^ flip_to_data(m);
        return d;
    endfunction

    function automatic logic [1:0] exp_st(logic [71:0] m);
        return 2'($countones(m));
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    task automatic do_write(logic [8:0] a, logic [63:0] d, logic [71:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_flip = m;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
        mdl_data[a] = d;
        mdl_flip[a] = m;
    endtask

    // read issued at edge E0; plain variant valid after E1, registered after E2
    task automatic do_read(logic [8:0] a, logic [63:0] ed, logic [1:0] es, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk({tag, " data"}, q0_data, ed);
        chk({tag, " status"}, {62'd0, q0_st}, {62'd0, es});
        chk("R7 registered variant not yet updated", q1_data, prev1_data);
        chk("R7 registered variant status not yet updated", {62'd0, q1_st}, {62'd0, prev1_st});
        @(negedge clk);
        chk("R8 data held without read", q0_data, ed);
        chk("R7 registered variant data one cycle later", q1_data, ed);
        chk("R7 registered variant status one cycle later", {62'd0, q1_st}, {62'd0, es});
        prev1_data = ed;
        prev1_st = es;
        chk("R5 status never 11", {63'd0, q0_st == 2'b11}, 64'd0);
    endtask

    task automatic read_model(logic [8:0] a, string tag);
        do_read(a, exp_data(mdl_data[a], mdl_flip[a]), exp_st(mdl_flip[a]), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [71:0] m;
        int dummy;
        dummy = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset data", q0_data, 64'd0);
        chk("R10 reset status", {62'd0, q0_st}, 64'd0);
        chk("R10 reset data registered", q1_data, 64'd0);
        chk("R10 reset status registered", {62'd0, q1_st}, 64'd0);

        // R1 clean write and read, boundary addresses
        do_write(9'd0, 64'hDEAD_BEEF_0123_4567, '0);
        do_write(9'd511, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        do_read(9'd0, 64'hDEAD_BEEF_0123_4567, 2'b00, "R1 clean addr 0");
        do_read(9'd511, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, "R1 clean addr 511");

        // R3 single flips on the parity bit, a check bit, the first and last data positions
        do_write(9'd5, 64'hA5A5_5A5A_0F0F_F0F0, 72'd1);
        do_read(9'd5, 64'hA5A5_5A5A_0F0F_F0F0, 2'b01, "R3 flip overall parity");
        do_write(9'd6, 64'h1234_5678_9ABC_DEF0, 72'd1 << 32);
        do_read(9'd6, 64'h1234_5678_9ABC_DEF0, 2'b01, "R3 flip check bit 32");
        do_write(9'd7, 64'h0, 72'd1 << 3);
        do_read(9'd7, 64'h0, 2'b01, "R3 flip data bit 0");
        do_write(9'd8, 64'hCAFE_F00D_CAFE_F00D, 72'd1 << 71);
        do_read(9'd8, 64'hCAFE_F00D_CAFE_F00D, 2'b01, "R3 flip data bit 63");

        // R6 repeated reads still see the stored fault until rewrite
        do_read(9'd5, 64'hA5A5_5A5A_0F0F_F0F0, 2'b01, "R6 repeat read 1");
        do_read(9'd8, 64'hCAFE_F00D_CAFE_F00D, 2'b01, "R6 repeat read 2");
        do_write(9'd8, 64'hCAFE_F00D_CAFE_F00D, '0);
        do_read(9'd8, 64'hCAFE_F00D_CAFE_F00D, 2'b00, "R6 cleared by rewrite");

        // R4 double flips: two data bits, data plus check bit, parity plus check bit
        do_write(9'd9, 64'h0, (72'd1 << 3) | (72'd1 << 5));
        do_read(9'd9, 64'h3, 2'b10, "R4 two data bits");
        do_write(9'd10, 64'hFFFF_0000_FFFF_0000, (72'd1 << 71) | (72'd1 << 4));
        do_read(9'd10, 64'h7FFF_0000_FFFF_0000, 2'b10, "R4 data and check bit");
        do_write(9'd11, 64'h5555_AAAA_5555_AAAA, 72'd1 | (72'd1 << 1));
        do_read(9'd11, 64'h5555_AAAA_5555_AAAA, 2'b10, "R4 parity and check bit");

        // R9 read-first on an address collision
        do_write(9'd20, 64'h1111_2222_3333_4444, '0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'd20; wr_data = 64'h9999_8888_7777_6666; wr_flip = '0;
        rd_en = 1'b1; rd_addr = 9'd20;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        chk("R9 collision returns old word", q0_data, 64'h1111_2222_3333_4444);
        @(negedge clk);
        chk("R9 collision registered variant", q1_data, 64'h1111_2222_3333_4444);
        prev1_data = 64'h1111_2222_3333_4444;
        prev1_st = 2'b00;
        mdl_data[20] = 64'h9999_8888_7777_6666;
        mdl_flip[20] = '0;
        do_read(9'd20, 64'h9999_8888_7777_6666, 2'b00, "R9 new word after collision");

        // random mix of clean, single and double faults (R1 R3 R4)
        for (int it = 0; it < 250; it++) begin
            logic [8:0] a;
            int cnt, b1, b2;
            a = 9'($urandom_range(0, 511));
            d = {$urandom(), $urandom()};
            m = '0;
            cnt = $urandom_range(0, 2);
            b1 = $urandom_range(0, 71);
            b2 = b1;
            while (b2 == b1) b2 = $urandom_range(0, 71);
            if (cnt >= 1) m[b1] = 1'b1;
            if (cnt == 2) m[b2] = 1'b1;
            do_write(a, d, m);
            used[n_used % 512] = a;
            if (n_used < 512) n_used++;
            read_model(used[$urandom_range(0, n_used - 1)], "R3 R4 random read");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule